// File: doc/BRIEF.md
# Cube Sharp Unit

This unit subtracts one cube from another. Given two cubes A and B over the same N variables, it returns the part of A that B does not cover, expressed as a set of up to N cubes. A larger minimisation engine uses it as its basic step when it checks whether a prime implicant still covers anything once the other primes and the don't-care cubes are taken away. Stepping through a whole set of primes is left to that engine.

Each coordinate is 2 bits wide: 01 means the variable is 0, 10 means it is 1, and 11 means it is free (x). Every coordinate pair is classified on its own. The unit then looks at all the coordinates together. If the two cubes are disjoint, A comes back unchanged. If A lies inside B, the result is empty. Otherwise A is split into one cube for each coordinate where A is free and B is fixed. Result slot i belongs to coordinate i, and a valid bitmap marks which slots are in use. The result is registered, so it appears one cycle after an input strobe.

Top module: `cube_sharp_unit`

## Requirements
- R1: Each coordinate uses the 2-bit code 01 = literal 0, 10 = literal 1, 11 = free. Coordinate i of a cube occupies bits [2i+1:2i]. The code 00 is never presented with an input strobe.
- R2: When `inValid` is high at a rising edge, `outValid` is high for exactly the following cycle, and the slots, valid bitmap and flags for that input are present in that same cycle.
- R3: If any coordinate pairs 0 with 1 or 1 with 0, then `resUnchanged` is 1, `slotValid` is 1 (only slot 0 in use), and slot 0 equals A.
- R4: If, for every coordinate, B is free or B equals A, then `resEmpty` is 1 and `slotValid` is 0.
- R5: In every other case, slot i is valid exactly when A's coordinate i is free and B's coordinate i is fixed. That slot holds A with coordinate i replaced by the complement of B's literal (01 becomes 10, 10 becomes 01).
- R6: `resUnchanged` and `resEmpty` are never both 1. Both are 0 for a split result.
- R7: Slot i occupies `resSlots` bits [i*2N + 2N-1 : i*2N]. Every slot whose valid bit is 0 reads as all zeros.
- R8: Cycles without a strobe leave the slots, bitmap and flags unchanged, and `outValid` stays low.
- R9: After reset, `outValid`, both flags, `slotValid` and `resSlots` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: the cubes on the inputs are to be processed |
| cubeA | input | 2*NUM_VARS | Minuend cube A |
| cubeB | input | 2*NUM_VARS | Subtrahend cube B |
| outValid | output | 1 | High in the cycle that carries a new result |
| resSlots | output | NUM_VARS*2*NUM_VARS | Result cubes, one slot per coordinate |
| slotValid | output | NUM_VARS | Valid bit for each result slot |
| resUnchanged | output | 1 | The result equals A |
| resEmpty | output | 1 | The result is empty |

## Verification
The assertions assume that no coordinate of either cube carries the code 00 in a strobe cycle. With that code, a coordinate could be both disjoint and covered, and the flags would stop being meaningful. The stimulus only ever builds a coordinate from the three legal codes, both in the directed cases and in the random ones. The assertions also assume that each strobe lasts exactly one cycle per input pair. The bench respects this, and when it sends strobes back to back, each one still carries a new pair.

// File: rtl/cube_sharp_pkg.sv
package cube_sharp_pkg;

  // Coordinate codes of a cube; 00 marks an empty coordinate and is illegal
  typedef enum logic [1:0] {
    COORD_VOID = 2'b00,
    COORD_ZERO = 2'b01,
    COORD_ONE  = 2'b10,
    COORD_FREE = 2'b11
  } coord_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadResult;
  } sharp_ctrl_t;

endpackage

// File: rtl/sharp_coord.sv
module sharp_coord (
  input  logic [1:0] aCoord,
  input  logic [1:0] bCoord,
  output logic       isDisjoint,
  output logic       isCovered,
  output logic       isSplit,
  output logic [1:0] flipCoord
);
  // No shared literal: the coordinate sets do not meet
  assign isDisjoint = ((aCoord & bCoord) == 2'b00);
  // Every literal A allows is also allowed by B
  assign isCovered  = ((aCoord & ~bCoord) == 2'b00);
  // Neither case: A is free while B is fixed
  assign isSplit    = !isDisjoint && !isCovered;
  // The literal B excludes
  assign flipCoord  = ~bCoord;
endmodule

// File: rtl/sharp_control.sv
module sharp_control
  import cube_sharp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output sharp_ctrl_t ctrl,
  output logic        outValid
);
  always_comb ctrl.loadResult = inValid;

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  // R2
  strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R8
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
endmodule

// File: rtl/sharp_datapath.sv
module sharp_datapath
  import cube_sharp_pkg::*;
#(
  parameter int NUM_VARS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  sharp_ctrl_t                  ctrl,
  input  logic [2*NUM_VARS-1:0]        cubeA,
  input  logic [2*NUM_VARS-1:0]        cubeB,
  output logic [NUM_VARS*2*NUM_VARS-1:0] resSlots,
  output logic [NUM_VARS-1:0]          slotValid,
  output logic                         resUnchanged,
  output logic                         resEmpty
);
  localparam int SLOT_W = 2 * NUM_VARS;
  localparam int RES_W  = NUM_VARS * SLOT_W;

  logic [NUM_VARS-1:0]      disjointVec;
  logic [NUM_VARS-1:0]      coveredVec;
  logic [NUM_VARS-1:0]      splitVec;
  logic [NUM_VARS-1:0][1:0] flipVec;

  for (genvar g = 0; g < NUM_VARS; g++) begin : g_coord
    sharp_coord u_coord (
      .aCoord    (cubeA[2*g +: 2]),
      .bCoord    (cubeB[2*g +: 2]),
      .isDisjoint(disjointVec[g]),
      .isCovered (coveredVec[g]),
      .isSplit   (splitVec[g]),
      .flipCoord (flipVec[g])
    );
  end

  logic [RES_W-1:0]    nextSlots;
  logic [NUM_VARS-1:0] nextValid;
  logic                nextUnchanged;
  logic                nextEmpty;
  logic [SLOT_W-1:0]   workCube;

  always_comb begin
    nextSlots     = '0;
    nextValid     = '0;
    nextUnchanged = 1'b0;
    nextEmpty     = 1'b0;
    workCube      = cubeA;
    if (|disjointVec) begin
      nextUnchanged         = 1'b1;
      nextValid[0]          = 1'b1;
      nextSlots[SLOT_W-1:0] = cubeA;
    end else if (&coveredVec) begin
      nextEmpty = 1'b1;
    end else begin
      for (int i = 0; i < NUM_VARS; i++) begin
        if (splitVec[i]) begin
          workCube                       = cubeA;
          workCube[2*i +: 2]             = flipVec[i];
          nextValid[i]                   = 1'b1;
          nextSlots[i*SLOT_W +: SLOT_W]  = workCube;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resSlots     <= '0;
      slotValid    <= '0;
      resUnchanged <= 1'b0;
      resEmpty     <= 1'b0;
    end else if (ctrl.loadResult) begin
      resSlots     <= nextSlots;
      slotValid    <= nextValid;
      resUnchanged <= nextUnchanged;
      resEmpty     <= nextEmpty;
    end
  end

  function automatic logic hasVoid(input logic [SLOT_W-1:0] c);
    logic found;
    found = 1'b0;
    for (int k = 0; k < NUM_VARS; k++)
      if (c[2*k +: 2] == COORD_VOID) found = 1'b1;
    return found;
  endfunction

  // R1
  legal_coord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.loadResult |-> (!hasVoid(cubeA) && !hasVoid(cubeB)));

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(resUnchanged && resEmpty));

  // R4
  empty_noslot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resEmpty |-> (slotValid == '0));

  // R3
  unchanged_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resUnchanged |-> (slotValid == NUM_VARS'(1)));

  // R5
  result_nonvoid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.loadResult |=> (resEmpty || (slotValid != '0)));

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.loadResult |=> ($stable(resSlots) && $stable(slotValid)
                          && $stable(resUnchanged) && $stable(resEmpty)));
endmodule

// File: rtl/cube_sharp_unit.sv
module cube_sharp_unit
  import cube_sharp_pkg::*;
#(
  parameter int NUM_VARS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           inValid,
  input  logic [2*NUM_VARS-1:0]          cubeA,
  input  logic [2*NUM_VARS-1:0]          cubeB,
  output logic                           outValid,
  output logic [NUM_VARS*2*NUM_VARS-1:0] resSlots,
  output logic [NUM_VARS-1:0]            slotValid,
  output logic                           resUnchanged,
  output logic                           resEmpty
);
  sharp_ctrl_t ctrl;

  sharp_control u_control (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .ctrl    (ctrl),
    .outValid(outValid)
  );

  sharp_datapath #(.NUM_VARS(NUM_VARS)) u_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl),
    .cubeA       (cubeA),
    .cubeB       (cubeB),
    .resSlots    (resSlots),
    .slotValid   (slotValid),
    .resUnchanged(resUnchanged),
    .resEmpty    (resEmpty)
  );
endmodule

// File: tb/test_cube_sharp_unit.sv
module test_cube_sharp_unit;
  localparam int N      = 4;
  localparam int SLOT_W = 2 * N;
  localparam int RES_W  = N * SLOT_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             inValid = 1'b0;
  logic [SLOT_W-1:0] cubeA = '0;
  logic [SLOT_W-1:0] cubeB = '0;
  logic             outValid;
  logic [RES_W-1:0] resSlots;
  logic [N-1:0]     slotValid;
  logic             resUnchanged;
  logic             resEmpty;

  cube_sharp_unit #(.NUM_VARS(N)) i_cube_sharp_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .cubeA(cubeA), .cubeB(cubeB),
    .outValid(outValid), .resSlots(resSlots), .slotValid(slotValid),
    .resUnchanged(resUnchanged), .resEmpty(resEmpty)
  );

  always #4 clk = ~clk; // 125 MHz

  typedef struct {
    logic [RES_W-1:0] slots;
    logic [N-1:0]     valid;
    logic             unch;
    logic             empt;
    int               due;
    string            tag;
  } exp_t;

  exp_t expQ[$];
  exp_t lastExp;
  bit   haveLast = 0;
  int   checks = 0;
  int   errors = 0;
  int   cycleCount = 0;
  bit   monitorOn = 0;

  always @(posedge clk) cycleCount <= cycleCount + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [RES_W-1:0] got, input logic [RES_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  // Reference model built from the per-coordinate sharp table (R1 codes)
  function automatic exp_t refSharp(input logic [SLOT_W-1:0] a, input logic [SLOT_W-1:0] b);
    exp_t e;
    bit anyNull = 0;
    bit allCov  = 1;
    logic [SLOT_W-1:0] c;
    e.slots = '0; e.valid = '0; e.unch = 0; e.empt = 0; e.due = 0;
    for (int i = 0; i < N; i++) begin
      logic [1:0] ai, bi;
      ai = a[2*i +: 2]; bi = b[2*i +: 2];
      if ((ai == 2'b01 && bi == 2'b10) || (ai == 2'b10 && bi == 2'b01)) anyNull = 1;
      if (!(bi == 2'b11 || ai == bi)) allCov = 0;
    end
    if (anyNull) begin
      e.unch = 1; e.valid = N'(1); e.slots[SLOT_W-1:0] = a; e.tag = "R3";
    end else if (allCov) begin
      e.empt = 1; e.tag = "R4";
    end else begin
      e.tag = "R5";
      for (int i = 0; i < N; i++) begin
        if (a[2*i +: 2] == 2'b11 && b[2*i +: 2] != 2'b11) begin
          c = a;
          c[2*i +: 2] = (b[2*i +: 2] == 2'b01) ? 2'b10 : 2'b01;
          e.valid[i] = 1;
          e.slots[i*SLOT_W +: SLOT_W] = c;
        end
      end
    end
    return e;
  endfunction

  task automatic sendPair(input logic [SLOT_W-1:0] a, input logic [SLOT_W-1:0] b);
    exp_t e;
    @(negedge clk);
    inValid = 1'b1; cubeA = a; cubeB = b;
    e = refSharp(a, b);
    e.due = cycleCount + 1;
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      cubeA = '0; cubeB = '0;
    end
  endtask

  function automatic logic [SLOT_W-1:0] randCube();
    logic [SLOT_W-1:0] c;
    for (int i = 0; i < N; i++)
      case ($urandom_range(0, 2))
        0:       c[2*i +: 2] = 2'b01;
        1:       c[2*i +: 2] = 2'b10;
        default: c[2*i +: 2] = 2'b11;
      endcase
    return c;
  endfunction

  // Monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (monitorOn) begin
        if (outValid) begin
          if (expQ.size() == 0) begin
            check(0, "R2", "unexpected outValid", RES_W'(1), '0);
          end else begin
            exp_t e;
            logic [RES_W-1:0] maskedGot;
            e = expQ.pop_front();
            check(e.due == cycleCount, "R2", "result cycle", RES_W'(cycleCount), RES_W'(e.due));
            check(slotValid == e.valid && resUnchanged == e.unch && resEmpty == e.empt,
                  e.tag, "bitmap/flags", {slotValid, resUnchanged, resEmpty},
                  {e.valid, e.unch, e.empt});
            check(!(resUnchanged && resEmpty), "R6", "flags both set",
                  {resUnchanged, resEmpty}, '0);
            maskedGot = '0;
            for (int i = 0; i < N; i++)
              if (e.valid[i]) maskedGot[i*SLOT_W +: SLOT_W] = resSlots[i*SLOT_W +: SLOT_W];
            check(maskedGot == e.slots, e.tag, "valid slot contents", maskedGot, e.slots);
            check(resSlots == e.slots, "R7", "unused slots zero", resSlots, e.slots);
            lastExp = e; haveLast = 1;
          end
        end else if (haveLast) begin
          check(resSlots == lastExp.slots && slotValid == lastExp.valid &&
                resUnchanged == lastExp.unch && resEmpty == lastExp.empt,
                "R8", "hold between strobes", resSlots, lastExp.slots);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired got %0d exp %0d", cycleCount, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check(outValid == 0 && resUnchanged == 0 && resEmpty == 0 && slotValid == 0,
          "R9", "reset flags", {outValid, resUnchanged, resEmpty, slotValid}, '0);
    check(resSlots == '0, "R9", "reset slots", resSlots, '0);
    rst_n = 1'b1;
    monitorOn = 1;
    idle(2);

    // R3: disjoint in coordinate 2 (A=1, B=0); A returned as is
    sendPair(8'b11_10_11_01, 8'b11_01_11_11);
    idle(3);
    // R4: A inside B (B all free)
    sendPair(8'b01_10_11_01, 8'b11_11_11_11);
    idle(2);
    // R4: identical cubes
    sendPair(8'b11_10_01_11, 8'b11_10_01_11);
    idle(1);
    // R5: A all free, B a single point -> all N slots
    sendPair(8'b11_11_11_11, 8'b10_01_10_01);
    idle(2);
    // R5: one split coordinate only
    sendPair(8'b01_11_10_01, 8'b01_10_11_11);
    // R2: back-to-back strobes
    sendPair(8'b11_11_01_10, 8'b01_11_01_11);
    sendPair(8'b10_11_11_11, 8'b01_11_11_11);
    sendPair(8'b11_01_11_10, 8'b11_11_10_11);
    idle(3);

    for (int n = 0; n < 300; n++) begin
      sendPair(randCube(), randCube());
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    idle(4);
    check(expQ.size() == 0, "R2", "results outstanding", RES_W'(expQ.size()), '0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule